// File: doc/BRIEF.md
# Radio Time-Code Decoder with Local Clock

This block turns the once-per-second pulse train of an amplitude-keyed time broadcast into a time-of-day and a calendar date. It takes a 1 ms tick enable and a carrier-level input that has already been synchronised and filtered. It counts ticks between carrier edges and sorts each interval into one of four classes: a short pulse (bit 0), a long pulse (bit 1), the minute gap, or noise. The noise class also covers the long idle part of every second.

Data bits fill a frame buffer that is indexed by bit position. When the minute gap arrives, the block checks the frame. A frame of exactly 59 bits with correct parity and a correct start bit loads minute, hour, day, weekday, month and year into the local clock. The minute gap always realigns the seconds and milliseconds, whether or not the frame is accepted.

Between markers the local clock runs on the tick input alone. The time of day therefore keeps advancing when no signal is received.

Top module: `radio_time_decoder`

## Requirements
- R1: The interval counter counts `tick_1ms` pulses since the last carrier edge. Any change of `carrier` (rising or falling) returns it to 0. An interval strictly greater than ZERO_LO and strictly less than ZERO_HI stores a 0 at the current bit index and advances the index.
- R2: An interval strictly greater than ZERO_HI and strictly less than ONE_HI stores a 1 at the current bit index and advances the index.
- R3: An interval strictly greater than MARK_LO and strictly less than MARK_HI is a minute marker. At the clock edge that samples it, the marker resets the bit index to 0 and clears `sec` and `ms`.
- R4: Any other interval does not advance the bit index. This includes the exact window limits 5/15/25/100/200 in the bench configuration and any interval of 0.
- R5: A marker commits the frame only if exactly 59 bits (indices 0..58) arrived since the previous marker. With fewer bits the frame is rejected. A 60th or later bit is discarded and marks the frame as over-long, which also rejects it.
- R6: The fields are BCD, least significant bit first, with bit weights 1,2,4,8,10,20,40,80. The fields sit at these bit indices: minute 21..27, hour 29..34, day 36..41, weekday 42..44, month 45..49, year 50..57. The outputs carry the binary value.
- R7: A frame is rejected unless bit 20 is 1 and each of three groups has an even number of ones: bits 21..28, bits 29..35 and bits 36..58.
- R8: An accepted frame loads all six fields at the marker's clock edge and raises `frame_valid` for exactly that one cycle.
- R9: A rejected marker leaves minute, hour, day, weekday, month and year unchanged.
- R10: The interval counter saturates at 2^CNT_W-1, where CNT_W = clog2(MARK_HI+1). An idle carrier therefore never wraps around into a bit or marker window.
- R11: `ms` counts ticks from 0 to MS_PER_SEC-1. `sec` and `minute` count 0..59 and `hour` counts 0..23. `day` increments when the hour wraps. With `tick_1ms` low, the clock holds.
- R12: After reset all time outputs are 0 and `frame_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_1ms | input | 1 | One-cycle enable per millisecond |
| carrier | input | 1 | Synchronised, filtered carrier level |
| ms | output | MS_W | Millisecond of the running clock |
| sec | output | 6 | Second of the running clock |
| minute | output | 7 | Minute of the running clock |
| hour | output | 6 | Hour of the running clock |
| day | output | 8 | Day of month (free-running increment) |
| weekday | output | 3 | Decoded weekday |
| month | output | 8 | Decoded month |
| year | output | 8 | Decoded two-digit year |
| frame_valid | output | 1 | One-cycle pulse on an accepted frame |

## Verification
The bench builds the decoder with all interval limits scaled down by ten (ZERO_LO=5, ZERO_HI=15, ONE_HI=25, MARK_LO=100, MARK_HI=200) and with MS_PER_SEC=100, and it holds the tick high every cycle. At this scale a full 59-bit frame costs only a few thousand cycles. This makes two things possible. First, a sweep that places every window limit and its neighbours at the last bit position of whole frames, for both values of the date parity. Second, a cycle-by-cycle comparison of the clock over a complete minute that ends in the hour and day wrap. The 8-bit interval counter that results from MARK_HI=200 lets a 406-tick silence test wrap-around against the marker window directly.

// File: rtl/rtd_pkg.sv
package rtd_pkg;

    localparam int FRAME_BITS = 59;
    localparam int KEEP_LO    = 20;

    localparam int POS_START  = 20;
    localparam int POS_MIN    = 21;
    localparam int LEN_MIN    = 7;
    localparam int POS_PMIN   = 28;
    localparam int POS_HOUR   = 29;
    localparam int LEN_HOUR   = 6;
    localparam int POS_PHOUR  = 35;
    localparam int POS_DAY    = 36;
    localparam int LEN_DAY    = 6;
    localparam int POS_WDAY   = 42;
    localparam int LEN_WDAY   = 3;
    localparam int POS_MON    = 45;
    localparam int LEN_MON    = 5;
    localparam int POS_YEAR   = 50;
    localparam int LEN_YEAR   = 8;
    localparam int POS_PDATE  = 58;

    typedef enum logic [1:0] {
        SYM_NONE,
        SYM_ZERO,
        SYM_ONE,
        SYM_MARK
    } sym_e;

    typedef struct packed {
        logic [6:0] minute;
        logic [5:0] hour;
        logic [7:0] day;
        logic [2:0] wday;
        logic [7:0] month;
        logic [7:0] year;
    } stamp_t;

    function automatic logic [7:0] bcd_weight(input int i);
        return (i < 4) ? 8'(1 << i) : 8'(10 << (i - 4));
    endfunction

    function automatic logic [7:0] bcd_field(input logic [FRAME_BITS-1:0] f,
                                             input int pos, input int len);
        logic [7:0] acc;
        acc = 8'd0;
        for (int i = 0; i < 8; i++) begin
            if (i < len) begin
                if (f[pos + i]) acc = acc + bcd_weight(i);
            end
        end
        return acc;
    endfunction

endpackage

// File: rtl/rtd_interval.sv
module rtd_interval
    import rtd_pkg::*;
#(
    parameter int ZERO_LO = 50,
    parameter int ZERO_HI = 150,
    parameter int ONE_HI  = 250,
    parameter int MARK_LO = 1000,
    parameter int MARK_HI = 2000,
    parameter int CNT_W   = 11,
    parameter bit IDLE_LV = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic carrier,
    output sym_e sym
);

    localparam logic [CNT_W-1:0] L_ZLO = CNT_W'(ZERO_LO);
    localparam logic [CNT_W-1:0] L_ZHI = CNT_W'(ZERO_HI);
    localparam logic [CNT_W-1:0] L_OHI = CNT_W'(ONE_HI);
    localparam logic [CNT_W-1:0] L_MLO = CNT_W'(MARK_LO);
    localparam logic [CNT_W-1:0] L_MHI = CNT_W'(MARK_HI);
    localparam logic [CNT_W-1:0] L_SAT = '1;

    typedef struct packed {
        logic             prev;
        logic [CNT_W-1:0] cnt;
    } ivl_t;

    ivl_t ivl_d, ivl_q;
    logic edge_seen;
    sym_e cls;

    always_comb begin
        edge_seen = carrier ^ ivl_q.prev;
        ivl_d      = ivl_q;
        ivl_d.prev = carrier;
        if (edge_seen)
            ivl_d.cnt = '0;
        else if (tick && ivl_q.cnt != L_SAT)
            ivl_d.cnt = ivl_q.cnt + 1'b1;

        if (ivl_q.cnt > L_ZLO && ivl_q.cnt < L_ZHI)
            cls = SYM_ZERO;
        else if (ivl_q.cnt > L_ZHI && ivl_q.cnt < L_OHI)
            cls = SYM_ONE;
        else if (ivl_q.cnt > L_MLO && ivl_q.cnt < L_MHI)
            cls = SYM_MARK;
        else
            cls = SYM_NONE;

        sym = edge_seen ? cls : SYM_NONE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ivl_q.prev <= IDLE_LV;
            ivl_q.cnt  <= '0;
        end else begin
            ivl_q <= ivl_d;
        end
    end

endmodule

// File: rtl/rtd_frame.sv
module rtd_frame
    import rtd_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  sym_e   sym,
    output logic   commit,
    output logic   frame_valid,
    output stamp_t stamp
);

    localparam int KEEP_N = FRAME_BITS - KEEP_LO;
    localparam int IDX_W  = $clog2(FRAME_BITS + 1);
    localparam logic [IDX_W-1:0] IDX_FULL = IDX_W'(FRAME_BITS);

    typedef struct packed {
        logic [KEEP_N-1:0] bits;
        logic [IDX_W-1:0]  idx;
        logic              ovr;
        logic              fv;
    } frm_t;

    frm_t frm_d, frm_q;
    logic [FRAME_BITS-1:0] full;
    logic                  checks_ok;

    always_comb begin
        full = {frm_q.bits, {KEEP_LO{1'b0}}};
        checks_ok = full[POS_START]
                  && !(^full[POS_PMIN:POS_MIN])
                  && !(^full[POS_PHOUR:POS_HOUR])
                  && !(^full[POS_PDATE:POS_DAY]);

        frm_d    = frm_q;
        frm_d.fv = 1'b0;
        commit   = 1'b0;

        case (sym)
            SYM_ZERO, SYM_ONE: begin
                if (frm_q.idx < IDX_FULL) begin
                    for (int i = KEEP_LO; i < FRAME_BITS; i++) begin
                        if (frm_q.idx == IDX_W'(i))
                            frm_d.bits[i - KEEP_LO] = (sym == SYM_ONE);
                    end
                    frm_d.idx = frm_q.idx + 1'b1;
                end else begin
                    frm_d.ovr = 1'b1;
                end
            end
            SYM_MARK: begin
                commit    = (frm_q.idx == IDX_FULL) && !frm_q.ovr && checks_ok;
                frm_d.idx = '0;
                frm_d.ovr = 1'b0;
                frm_d.fv  = commit;
            end
            default: ;
        endcase

        stamp.minute = 7'(bcd_field(full, POS_MIN,  LEN_MIN));
        stamp.hour   = 6'(bcd_field(full, POS_HOUR, LEN_HOUR));
        stamp.day    = bcd_field(full, POS_DAY,  LEN_DAY);
        stamp.wday   = 3'(bcd_field(full, POS_WDAY, LEN_WDAY));
        stamp.month  = bcd_field(full, POS_MON,  LEN_MON);
        stamp.year   = bcd_field(full, POS_YEAR, LEN_YEAR);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) frm_q <= '0;
        else        frm_q <= frm_d;
    end

    assign frame_valid = frm_q.fv;

endmodule

// File: rtl/rtd_clock.sv
module rtd_clock
    import rtd_pkg::*;
#(
    parameter int MS_PER_SEC = 1000,
    parameter int MS_W       = 10
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            tick,
    input  logic            resync,
    input  logic            load,
    input  stamp_t          stamp,
    output logic [MS_W-1:0] ms,
    output logic [5:0]      sec,
    output stamp_t          now
);

    localparam logic [MS_W-1:0] MS_LAST = MS_W'(MS_PER_SEC - 1);

    typedef struct packed {
        logic [MS_W-1:0] ms;
        logic [5:0]      sec;
        stamp_t          t;
    } clk_t;

    clk_t clk_d, clk_q;

    always_comb begin
        clk_d = clk_q;
        if (tick) begin
            if (clk_q.ms >= MS_LAST) begin
                clk_d.ms = '0;
                if (clk_q.sec >= 6'd59) begin
                    clk_d.sec = '0;
                    if (clk_q.t.minute >= 7'd59) begin
                        clk_d.t.minute = '0;
                        if (clk_q.t.hour >= 6'd23) begin
                            clk_d.t.hour = '0;
                            clk_d.t.day  = clk_q.t.day + 1'b1;
                        end else begin
                            clk_d.t.hour = clk_q.t.hour + 1'b1;
                        end
                    end else begin
                        clk_d.t.minute = clk_q.t.minute + 1'b1;
                    end
                end else begin
                    clk_d.sec = clk_q.sec + 1'b1;
                end
            end else begin
                clk_d.ms = clk_q.ms + 1'b1;
            end
        end
        if (resync) begin
            clk_d.ms  = '0;
            clk_d.sec = '0;
        end
        if (load)
            clk_d.t = stamp;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) clk_q <= '0;
        else        clk_q <= clk_d;
    end

    assign ms  = clk_q.ms;
    assign sec = clk_q.sec;
    assign now = clk_q.t;

endmodule

// File: rtl/radio_time_decoder.sv
module radio_time_decoder
    import rtd_pkg::*;
#(
    parameter int ZERO_LO    = 50,
    parameter int ZERO_HI    = 150,
    parameter int ONE_HI     = 250,
    parameter int MARK_LO    = 1000,
    parameter int MARK_HI    = 2000,
    parameter int MS_PER_SEC = 1000,
    parameter int MS_W       = $clog2(MS_PER_SEC)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            tick_1ms,
    input  logic            carrier,
    output logic [MS_W-1:0] ms,
    output logic [5:0]      sec,
    output logic [6:0]      minute,
    output logic [5:0]      hour,
    output logic [7:0]      day,
    output logic [2:0]      weekday,
    output logic [7:0]      month,
    output logic [7:0]      year,
    output logic            frame_valid
);

    localparam int CNT_W = $clog2(MARK_HI + 1);

    sym_e   sym;
    logic   commit;
    logic   marker;
    stamp_t rx_stamp;
    stamp_t now;

    rtd_interval #(
        .ZERO_LO(ZERO_LO), .ZERO_HI(ZERO_HI), .ONE_HI(ONE_HI),
        .MARK_LO(MARK_LO), .MARK_HI(MARK_HI), .CNT_W(CNT_W), .IDLE_LV(1'b1)
    ) u_interval (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick_1ms),
        .carrier (carrier),
        .sym     (sym)
    );

    rtd_frame u_frame (
        .clk         (clk),
        .rst_n       (rst_n),
        .sym         (sym),
        .commit      (commit),
        .frame_valid (frame_valid),
        .stamp       (rx_stamp)
    );

    assign marker = (sym == SYM_MARK);

    rtd_clock #(.MS_PER_SEC(MS_PER_SEC), .MS_W(MS_W)) u_clock (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick   (tick_1ms),
        .resync (marker),
        .load   (commit),
        .stamp  (rx_stamp),
        .ms     (ms),
        .sec    (sec),
        .now    (now)
    );

    assign minute  = now.minute;
    assign hour    = now.hour;
    assign day     = now.day;
    assign weekday = now.wday;
    assign month   = now.month;
    assign year    = now.year;

endmodule

// File: rtl/rtd_checker.sv
module rtd_checker #(
    parameter int MS_PER_SEC = 1000,
    parameter int MS_W       = 10
) (
    input logic            clk,
    input logic            rst_n,
    input logic            tick_1ms,
    input logic            carrier,
    input logic [MS_W-1:0] ms,
    input logic [5:0]      sec,
    input logic            frame_valid
);

    // R8: an accepted frame is flagged for a single cycle only
    a_r8_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        frame_valid |=> !frame_valid);

    // R8: a commit is always caused by a carrier edge seen at that clock edge
    a_r8_commit_on_edge: assert property (@(posedge clk) disable iff (!rst_n)
        frame_valid |-> $past(carrier) != $past(carrier, 2));

    // R3: the marker that commits also realigns the seconds
    a_r3_commit_resync: assert property (@(posedge clk) disable iff (!rst_n)
        frame_valid |-> (sec == 6'd0 && ms == '0));

    // R11: millisecond and second stay in range
    a_r11_ms_range: assert property (@(posedge clk) disable iff (!rst_n)
        ms < MS_W'(MS_PER_SEC));

    a_r11_sec_range: assert property (@(posedge clk) disable iff (!rst_n)
        sec < 6'd60);

    // R11: without a tick the millisecond only moves by a marker clear
    a_r11_hold_no_tick: assert property (@(posedge clk) disable iff (!rst_n)
        !tick_1ms |=> (ms == $past(ms) || ms == '0));

endmodule

bind radio_time_decoder rtd_checker #(.MS_PER_SEC(MS_PER_SEC), .MS_W(MS_W)) u_rtd_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .tick_1ms    (tick_1ms),
    .carrier     (carrier),
    .ms          (ms),
    .sec         (sec),
    .frame_valid (frame_valid)
);

// File: tb/radio_time_decoder_bench.sv
module radio_time_decoder_bench;

    localparam int ZLO = 5, ZHI = 15, OHI = 25, MLO = 100, MHI = 200, MSPS = 100;
    localparam int MSW = $clog2(MSPS);

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           tick_1ms = 1'b0;
    logic           carrier = 1'b1;
    logic [MSW-1:0] ms;
    logic [5:0]     sec;
    logic [6:0]     minute;
    logic [5:0]     hour;
    logic [7:0]     day;
    logic [2:0]     weekday;
    logic [7:0]     month;
    logic [7:0]     year;
    logic           frame_valid;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    radio_time_decoder #(
        .ZERO_LO(ZLO), .ZERO_HI(ZHI), .ONE_HI(OHI),
        .MARK_LO(MLO), .MARK_HI(MHI), .MS_PER_SEC(MSPS)
    ) u_radio_time_decoder (
        .clk(clk), .rst_n(rst_n), .tick_1ms(tick_1ms), .carrier(carrier),
        .ms(ms), .sec(sec), .minute(minute), .hour(hour), .day(day),
        .weekday(weekday), .month(month), .year(year), .frame_valid(frame_valid)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic logic [58:0] make_frame(input int mi, input int hr, input int dy,
                                                input int wd, input int mo, input int yr);
        logic [58:0] f;
        f = '0;
        f[20] = 1'b1;
        for (int i = 0; i < 7; i++) f[21 + i] = 1'(((mi / 10) * 16 + mi % 10) >> i);
        for (int i = 0; i < 6; i++) f[29 + i] = 1'(((hr / 10) * 16 + hr % 10) >> i);
        for (int i = 0; i < 6; i++) f[36 + i] = 1'(((dy / 10) * 16 + dy % 10) >> i);
        for (int i = 0; i < 3; i++) f[42 + i] = 1'(wd >> i);
        for (int i = 0; i < 5; i++) f[45 + i] = 1'(((mo / 10) * 16 + mo % 10) >> i);
        for (int i = 0; i < 8; i++) f[50 + i] = 1'(((yr / 10) * 16 + yr % 10) >> i);
        f[28] = ^f[27:21];
        f[35] = ^f[34:29];
        f[58] = ^f[57:36];
        return f;
    endfunction

    // the next edge is sampled with an interval count of exactly d
    task automatic edge_after(input int d);
        repeat (d + 1) @(negedge clk);
        carrier = ~carrier;
    endtask

    task automatic send_bit(input logic b);
        edge_after(30);
        edge_after(b ? 20 : 10);
    endtask

    task automatic send_bits(input logic [58:0] f, input int n);
        for (int i = 0; i < n; i++) send_bit(f[i]);
    endtask

    task automatic marker(output logic fv);
        edge_after(150);
        @(negedge clk);
        fv = frame_valid;
    endtask

    task automatic chk_fields(input string req, input int mi, input int hr, input int dy,
                              input int wd, input int mo, input int yr);
        chk({req, " minute"},  int'(minute),  mi);
        chk({req, " hour"},    int'(hour),    hr);
        chk({req, " day"},     int'(day),     dy);
        chk({req, " weekday"}, int'(weekday), wd);
        chk({req, " month"},   int'(month),   mo);
        chk({req, " year"},    int'(year),    yr);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got 0 expected 1 (run completed)");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic        fv;
        logic [58:0] f;
        int          sweep [13] = '{4, 5, 6, 14, 15, 16, 24, 25, 26, 101, 150, 199, 300};
        int          ign [7]    = '{5, 15, 25, 100, 200, 60, 0};

        repeat (3) @(negedge clk);
        // R12: reset state
        chk("R12 ms", int'(ms), 0);
        chk("R12 sec", int'(sec), 0);
        chk_fields("R12", 0, 0, 0, 0, 0, 0);
        chk("R12 frame_valid", int'(frame_valid), 0);
        rst_n    = 1'b1;
        tick_1ms = 1'b1;

        // R1 R2 R6 R8: a clean frame loads all fields
        send_bits(make_frame(37, 14, 25, 3, 11, 23), 59);
        marker(fv);
        chk("R8 frame_valid on accept", int'(fv), 1);
        chk_fields("R6", 37, 14, 25, 3, 11, 23);
        chk("R3 sec cleared", int'(sec), 0);
        chk("R3 ms cleared", int'(ms), 0);
        @(negedge clk);
        chk("R8 frame_valid one cycle", int'(frame_valid), 0);

        // R7 R9: bad minute parity
        f = make_frame(5, 6, 7, 1, 2, 30);
        f[28] = ~f[28];
        send_bits(f, 59);
        marker(fv);
        chk("R7 minute parity reject", int'(fv), 0);
        chk_fields("R9", 37, 14, 25, 3, 11, 23);
        chk("R3 sec cleared on reject", int'(sec), 0);

        // R7: bad hour parity and bad date parity
        f = make_frame(5, 6, 7, 1, 2, 30);
        f[35] = ~f[35];
        send_bits(f, 59);
        marker(fv);
        chk("R7 hour parity reject", int'(fv), 0);
        f = make_frame(5, 6, 7, 1, 2, 30);
        f[58] = ~f[58];
        send_bits(f, 59);
        marker(fv);
        chk("R7 date parity reject", int'(fv), 0);

        // R7: start bit 20 cleared
        f = make_frame(5, 6, 7, 1, 2, 30);
        f[20] = 1'b0;
        send_bits(f, 59);
        marker(fv);
        chk("R7 start bit reject", int'(fv), 0);
        chk_fields("R9", 37, 14, 25, 3, 11, 23);

        // R5: short and long frames
        send_bits(make_frame(5, 6, 7, 1, 2, 30), 58);
        marker(fv);
        chk("R5 58 bits reject", int'(fv), 0);
        send_bits(make_frame(5, 6, 7, 1, 2, 30), 59);
        send_bit(1'b0);
        marker(fv);
        chk("R5 60 bits reject", int'(fv), 0);
        chk_fields("R5", 37, 14, 25, 3, 11, 23);

        // R4: boundary and zero intervals between bits are ignored
        f = make_frame(48, 21, 9, 5, 6, 42);
        for (int i = 0; i < 59; i++) begin
            send_bit(f[i]);
            if (i < 7) edge_after(ign[i]);
        end
        marker(fv);
        chk("R4 ignored intervals keep count", int'(fv), 1);
        chk_fields("R4", 48, 21, 9, 5, 6, 42);

        // R10: a 406-tick silence must not wrap into the marker window
        send_bits(make_frame(2, 3, 4, 6, 7, 8), 59);
        edge_after(406);
        @(negedge clk);
        chk("R10 saturated silence no commit", int'(frame_valid), 0);
        chk_fields("R10", 48, 21, 9, 5, 6, 42);
        marker(fv);
        chk("R10 marker after silence", int'(fv), 1);
        chk_fields("R10", 2, 3, 4, 6, 7, 8);

        // R1 R2 R4 R3: sweep window limits at the last bit position
        for (int p = 0; p < 2; p++) begin
            f = make_frame(12, 8, (p == 0) ? 3 : 1, 2, 4, 17);
            for (int k = 0; k < 13; k++) begin
                int cls;
                int d;
                d   = sweep[k];
                cls = (d > ZLO && d < ZHI) ? 0 : (d > ZHI && d < OHI) ? 1 : 2;
                send_bits(f, 58);
                edge_after(30);
                edge_after(d);
                marker(fv);
                if (int'(f[58]) == 0)
                    chk($sformatf("R1 sweep d=%0d bit0", d), int'(fv), (cls == 0) ? 1 : 0);
                else
                    chk($sformatf("R2 sweep d=%0d bit1", d), int'(fv), (cls == 1) ? 1 : 0);
            end
        end

        // R11: a full minute from 23:59 wraps hour and day
        send_bits(make_frame(59, 23, 30, 7, 12, 99), 59);
        marker(fv);
        chk("R8 rollover load", int'(fv), 1);
        for (int k = 1; k <= 6000; k++) begin
            @(negedge clk);
            if (k % 100 == 0 || k > 5990) begin
                chk("R11 ms", int'(ms), k % MSPS);
                chk("R11 sec", int'(sec), (k / MSPS) % 60);
            end
        end
        chk("R11 minute wrap", int'(minute), 0);
        chk("R11 hour wrap", int'(hour), 0);
        chk("R11 day increment", int'(day), 31);

        // R11: clock holds with tick low
        repeat (37) @(negedge clk);
        tick_1ms = 1'b0;
        begin
            int held;
            held = int'(ms);
            repeat (50) @(negedge clk);
            chk("R11 hold without tick", int'(ms), held);
        end
        tick_1ms = 1'b1;
        @(negedge clk);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule